// File: doc/BRIEF.md
# Audio Coprocessor Address Decoder with Boot-ROM Overlay

This block sits on the 16-bit address bus of a small audio coprocessor. It decides the target of every coprocessor read and write: an external synchronous 64 KiB RAM, a 64-byte boot ROM that overlays the top of the address space, a control register, or one of four mailbox ports shared with a host processor. The control register also supplies the enable bits that a neighbouring timer block consumes.

Each mailbox address has two latches. The host fills an inbound latch through a strobe, a 2-bit port index and a data byte. The strobe passes through a two-flop synchroniser before the latch updates. A coprocessor read of the mailbox address returns the inbound latch. A coprocessor write to the same address fills a separate outbound latch, which the host reads through its own index. The boot ROM is visible after reset and can be hidden by a control bit, which exposes the RAM underneath. Writes into the ROM window always go to RAM.

Top module: `apu_addr_decoder`

## Requirements
- R1: After a synchronous active-low reset, the control register, all four inbound latches and all four outbound latches are zero, `timer_en` is 0 and the ROM is visible (`rom_hidden` = 0).
- R2: While the ROM is visible, reads of 0xFFC0..0xFFFF return ROM bytes: 0xFFC0 reads 0xCD, 0xFFFE reads 0xC0 and 0xFFFF reads 0xFF, so the reset vector is 0xFFC0.
- R3: Writing the control register at 0xF1 with bit 7 = 1 makes 0xFFC0..0xFFFF read from RAM. Writing bit 7 = 0 makes the ROM visible again. `rom_hidden` shows bit 7.
- R4: A coprocessor write to 0xFFC0..0xFFFF reaches RAM (`ram_we` = 1) whether or not the ROM is visible.
- R5: A host write with `host_stb` high, port index k (0..3) and a data byte makes a coprocessor read of 0xF4+k return that byte within four clock edges of the strobe rising. The other ports do not change.
- R6: A coprocessor write to 0xF4+k sets outbound latch k, which appears on `host_rdata` when `host_ridx` = k. The inbound latch k keeps its value.
- R7: Every read returns its data on `cpu_rdata` in the cycle after the request, whether the source is RAM, ROM, control register or mailbox. Back-to-back reads from different sources each return their own data.
- R8: Control bits [2:0] drive `timer_en[2:0]`. A read of 0xF1 returns the whole control register.
- R9: Addresses outside 0xF1, 0xF4..0xF7 and the visible ROM window go to RAM. Writes to 0xF1 and 0xF4..0xF7 never assert `ram_we`.
- R10: When an inbound latch update and a coprocessor read of the same port fall on the same clock edge, the read returns the old byte whole. Every later read returns the new byte. No read returns a mix of the two, and no read returns the old byte after the new one has appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coprocessor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Coprocessor address |
| cpu_rd | input | 1 | Read request, sampled at the clock edge |
| cpu_wr | input | 1 | Write request, sampled at the clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after the request |
| ram_addr | output | 16 | RAM address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |
| host_stb | input | 1 | Host write strobe (asynchronous, held for at least 3 cycles) |
| host_idx | input | 2 | Host write port index |
| host_wdata | input | 8 | Host write data, stable while the strobe is high |
| host_ridx | input | 2 | Host read port index |
| host_rdata | output | 8 | Selected outbound latch |
| timer_en | output | 3 | Timer enable bits from the control register |
| rom_hidden | output | 1 | High when the ROM window reads from RAM |

## Verification
Two functions can land on the same clock edge: the synchronised host update of an inbound latch, and a coprocessor read of that same mailbox address. The bench seeds port 0 with a known byte. It then starts a host write of a different byte and, in parallel, issues eight back-to-back coprocessor reads of 0xF4, so that one read shares its edge with the latch update. The scoreboard accepts only the old or the new byte. It flags any read that returns the old byte after the new one, and it requires the new byte to appear before the burst ends.

// File: rtl/apu_dec_pkg.sv
// Package: shared constants and the read-source type for the audio
// coprocessor address decoder. Assumes a 16-bit address bus.
package apu_dec_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Fixed register addresses in the low page
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'h00F1;
    localparam logic [ADDR_W-1:0] MBOX_BASE = 16'h00F4;

    // Control register bit that hides the boot ROM
    localparam int HIDE_BIT = 7;

    // Source of the data returned for a read
    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_ROM  = 2'd1,
        SRC_CTRL = 2'd2,
        SRC_MBOX = 2'd3
    } rd_src_e;

endpackage

// File: rtl/apu_boot_rom.sv
// Module: apu_boot_rom
// Purpose: combinational boot ROM for the top of the address space. The
// first byte holds 0xCD. The last two bytes hold the reset vector, which
// points to the first ROM address. All other bytes come from a fixed
// formula.
// Assumes: DEPTH is a power of two and less than 2**ADDR_W.
module apu_boot_rom #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0]     idx,
    output logic [DATA_W-1:0] data
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((2 ** ADDR_W) - DEPTH);

    // Byte value for each ROM location
    function automatic logic [DATA_W-1:0] rom_byte(input int i);
        if (i == 0)
            return DATA_W'(8'hCD);
        else if (i == DEPTH - 2)
            return DATA_W'(BASE[7:0]);
        else if (i == DEPTH - 1)
            return DATA_W'(BASE[15:8]);
        else
            return DATA_W'((i * 37 + 11) & 8'hFF);
    endfunction

    // Look up the addressed byte
    always_comb begin
        data = rom_byte(int'(idx));
    end

endmodule

// File: rtl/apu_ctrl_reg.sv
// Module: apu_ctrl_reg
// Purpose: holds the coprocessor control register. Bit HIDE_BIT hides the
// boot ROM. The low NTMR bits enable the timers.
// Assumes: wr_en is already decoded for the control address.
module apu_ctrl_reg #(
    parameter int DATA_W = 8,
    parameter int NTMR   = 3,
    parameter int HIDE   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              hide_rom,
    output logic [NTMR-1:0]   timer_en
);

    // Load the register on a decoded write; clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wdata;
    end

    assign hide_rom = ctrl_q[HIDE];
    assign timer_en = ctrl_q[NTMR-1:0];

    // R1
    ctrl_rst_zero_chk: assert property (@(posedge clk) !rst_n |=> (ctrl_q == '0));

    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/apu_mailbox.sv
// Module: apu_mailbox
// Purpose: the four-port mailbox between host and coprocessor. Inbound
// latches are filled by the host after a two-flop synchroniser on the host
// strobe. Outbound latches are filled by coprocessor writes and read by the
// host through an index.
// Assumes: host_idx and host_wdata stay stable while host_stb is high, and
// the strobe stays high for at least three clock cycles.
module apu_mailbox #(
    parameter int DATA_W = 8,
    parameter int NPORT  = 4,
    localparam int PIW   = $clog2(NPORT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_stb,
    input  logic [PIW-1:0]               host_idx,
    input  logic [DATA_W-1:0]            host_wdata,
    input  logic [PIW-1:0]               host_ridx,
    output logic [DATA_W-1:0]            host_rdata,
    input  logic                         cpu_wr_en,
    input  logic [PIW-1:0]               cpu_idx,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [NPORT-1:0][DATA_W-1:0] in_q,
    output logic [NPORT-1:0][DATA_W-1:0] out_q
);

    logic stb_s1, stb_s2, stb_s3;
    logic upd;

    // Synchronise the host strobe and keep one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_s1 <= 1'b0;
            stb_s2 <= 1'b0;
            stb_s3 <= 1'b0;
        end else begin
            stb_s1 <= host_stb;
            stb_s2 <= stb_s1;
            stb_s3 <= stb_s2;
        end
    end

    assign upd = stb_s2 & ~stb_s3;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Inbound latch p: loaded once per synchronised host strobe
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_q[p] <= '0;
            else if (upd && (host_idx == PIW'(p)))
                in_q[p] <= host_wdata;
        end

        // Outbound latch p: loaded by a coprocessor write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q[p] <= '0;
            else if (cpu_wr_en && (cpu_idx == PIW'(p)))
                out_q[p] <= cpu_wdata;
        end
    end

    assign host_rdata = out_q[host_ridx];

    // R10
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    // R6
    in_stable_on_cpu_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && !upd) |=> $stable(in_q));

    // R5
    out_stable_on_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !cpu_wr_en) |=> $stable(out_q));

    // R1
    mbox_rst_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (in_q == '0 && out_q == '0));

endmodule

// File: rtl/apu_addr_decoder.sv
// Module: apu_addr_decoder (top)
// Purpose: decodes the coprocessor address bus. It routes reads and writes
// to the external synchronous RAM, the boot ROM overlay, the control
// register and the mailbox. Read data from every source returns one cycle
// after the request.
// Assumes: the external RAM returns read data one cycle after ram_re, and
// cpu_rd and cpu_wr are never high together.
module apu_addr_decoder
    import apu_dec_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int DW        = DATA_W,
    parameter int NPORT     = 4,
    parameter int ROM_BYTES = 64,
    parameter int NTMR      = 3,
    localparam int PIW      = $clog2(NPORT),
    localparam int RIW      = $clog2(ROM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic [AW-1:0]    ram_addr,
    output logic             ram_re,
    output logic             ram_we,
    output logic [DW-1:0]    ram_wdata,
    input  logic [DW-1:0]    ram_rdata,
    input  logic             host_stb,
    input  logic [PIW-1:0]   host_idx,
    input  logic [DW-1:0]    host_wdata,
    input  logic [PIW-1:0]   host_ridx,
    output logic [DW-1:0]    host_rdata,
    output logic [NTMR-1:0]  timer_en,
    output logic             rom_hidden
);

    localparam logic [AW-1:0] ROM_BASE = AW'((2 ** AW) - ROM_BYTES);
    localparam logic [AW-1:0] VEC_LO   = AW'((2 ** AW) - 2);
    localparam logic [AW-1:0] MB_BASE  = AW'(MBOX_BASE);
    localparam logic [AW-1:0] MB_END   = AW'(MBOX_BASE + NPORT);
    localparam logic [AW-1:0] CT_ADDR  = AW'(CTRL_ADDR);

    logic                     hit_ctrl, hit_mbox, hit_rom;
    rd_src_e                  src_now, src_q;
    logic [DW-1:0]            lcl_now, lcl_q;
    logic [DW-1:0]            ctrl_q, rom_data;
    logic                     hide_rom;
    logic [PIW-1:0]           mbox_idx;
    logic [NPORT-1:0][DW-1:0] in_q, out_q;

    // Classify the current address
    always_comb begin
        hit_ctrl = (cpu_addr == CT_ADDR);
        hit_mbox = (cpu_addr >= MB_BASE) && (cpu_addr < MB_END);
        hit_rom  = (cpu_addr >= ROM_BASE);
        mbox_idx = cpu_addr[PIW-1:0];
    end

    // Choose the read source; the ROM wins only while it is visible
    always_comb begin
        if (hit_ctrl)
            src_now = SRC_CTRL;
        else if (hit_mbox)
            src_now = SRC_MBOX;
        else if (hit_rom && !hide_rom)
            src_now = SRC_ROM;
        else
            src_now = SRC_RAM;
    end

    // Pick the local (non-RAM) read data for the current address
    always_comb begin
        unique case (src_now)
            SRC_CTRL: lcl_now = ctrl_q;
            SRC_MBOX: lcl_now = in_q[mbox_idx];
            SRC_ROM:  lcl_now = rom_data;
            default:  lcl_now = '0;
        endcase
    end

    // Drive the RAM port: reads only when RAM is the source, writes except to registers
    always_comb begin
        ram_addr  = cpu_addr;
        ram_wdata = cpu_wdata;
        ram_re    = cpu_rd && (src_now == SRC_RAM);
        ram_we    = cpu_wr && !hit_ctrl && !hit_mbox;
    end

    // Register the read source and local data so all sources return a cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_CTRL;
            lcl_q <= '0;
        end else if (cpu_rd) begin
            src_q <= src_now;
            lcl_q <= lcl_now;
        end
    end

    assign cpu_rdata  = (src_q == SRC_RAM) ? ram_rdata : lcl_q;
    assign rom_hidden = hide_rom;

    apu_boot_rom #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .DEPTH  (ROM_BYTES)
    ) u_rom (
        .idx  (cpu_addr[RIW-1:0]),
        .data (rom_data)
    );

    apu_ctrl_reg #(
        .DATA_W (DW),
        .NTMR   (NTMR),
        .HIDE   (HIDE_BIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr && hit_ctrl),
        .wdata    (cpu_wdata),
        .ctrl_q   (ctrl_q),
        .hide_rom (hide_rom),
        .timer_en (timer_en)
    );

    apu_mailbox #(
        .DATA_W (DW),
        .NPORT  (NPORT)
    ) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_stb   (host_stb),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_ridx  (host_ridx),
        .host_rdata (host_rdata),
        .cpu_wr_en  (cpu_wr && hit_mbox),
        .cpu_idx    (mbox_idx),
        .cpu_wdata  (cpu_wdata),
        .in_q       (in_q),
        .out_q      (out_q)
    );

    // R2
    rom_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == VEC_LO && !rom_hidden) |=> (cpu_rdata == DW'(ROM_BASE[7:0])));

    // R3
    hidden_reads_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= ROM_BASE && rom_hidden) |-> ram_re);

    // R4
    rom_write_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr >= ROM_BASE) |-> (ram_we && ram_addr == cpu_addr));

    // R9
    reg_write_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr == CT_ADDR || (cpu_addr >= MB_BASE && cpu_addr < MB_END))) |-> !ram_we);

    // R8
    timer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == CT_ADDR) |=> (timer_en == $past(cpu_wdata[NTMR-1:0])));

endmodule

// File: tb/tb_apu_addr_decoder.sv
`timescale 1ns/1ps
module tb_apu_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic [15:0] ram_addr;
    logic        ram_re, ram_we;
    logic [7:0]  ram_wdata, ram_rdata;
    logic        host_stb = 1'b0;
    logic [1:0]  host_idx = '0, host_ridx = '0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic [2:0]  timer_en;
    logic        rom_hidden;

    int total = 0, bad = 0;
    bit done = 0;
    bit race_new_seen = 0;

    always #4 clk = ~clk;

    apu_addr_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_re(ram_re),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .host_stb(host_stb),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_ridx(host_ridx),
        .host_rdata(host_rdata), .timer_en(timer_en), .rom_hidden(rom_hidden)
    );

    // Synchronous RAM model, cleared at start
    logic [7:0] mem [0:65535];
    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
        ram_rdata = 8'h00;
    end
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    // Scoreboard
    typedef struct {
        logic [7:0] exp;
        logic [7:0] alt;
        bit         race;
        string      req;
    } item_t;
    item_t sb[$];
    logic rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= cpu_rd;

    // Monitor: compare each returned read against the queue
    always @(negedge clk) begin
        if (rd_seen && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (it.race) begin
                if (cpu_rdata == it.alt) race_new_seen = 1;
                else if (!(cpu_rdata == it.exp && !race_new_seen)) begin
                    bad++;
                    $display("FAIL %s: race read got %02h, expected %02h or %02h (new seen=%0d)",
                             it.req, cpu_rdata, it.exp, it.alt, race_new_seen);
                end
            end else if (cpu_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s: read got %02h, expected %02h", it.req, cpu_rdata, it.exp);
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h, expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [15:0] a, input logic [7:0] e, input string req,
                            input bit race = 0, input logic [7:0] alt = 8'h00);
        item_t it;
        @(negedge clk);
        it.exp = e; it.alt = alt; it.race = race; it.req = req;
        sb.push_back(it);
        cpu_addr = a; cpu_rd = 1'b1;
        @(posedge clk); #1;
        cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] k, input logic [7:0] d);
        @(negedge clk);
        host_idx = k; host_wdata = d; host_stb = 1'b1;
        repeat (4) @(posedge clk);
        #1 host_stb = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic drain();
        repeat (2) @(posedge clk);
        chk(16'(sb.size()), 16'd0, "scoreboard drained");
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(16'(timer_en), 16'h0, "R1 timer_en");
        chk(16'(rom_hidden), 16'h0, "R1 rom_hidden");
        for (int k = 0; k < 4; k++) begin
            host_ridx = 2'(k); #1;
            chk(16'(host_rdata), 16'h0, "R1 outbound latch");
        end
        for (int k = 0; k < 4; k++) cpu_read(16'h00F4 + 16'(k), 8'h00, "R1 inbound latch");
        cpu_read(16'h00F1, 8'h00, "R1 control register");
        cpu_read(16'hFFC0, 8'hCD, "R1 ROM visible");

        // R2 ROM bytes
        cpu_read(16'hFFFE, 8'hC0, "R2 vector low");
        cpu_read(16'hFFFF, 8'hFF, "R2 vector high");

        // R4 write into ROM window while visible
        cpu_write(16'hFFC0, 8'h42);
        cpu_read(16'hFFC0, 8'hCD, "R4 ROM still visible after write");
        drain();
        chk(16'(mem[16'hFFC0]), 16'h42, "R4 RAM under ROM written");

        // R3 hide and reveal
        cpu_write(16'h00F1, 8'h80);
        @(negedge clk);
        chk(16'(rom_hidden), 16'h1, "R3 rom_hidden set");
        cpu_read(16'hFFC0, 8'h42, "R3 hidden reads RAM");
        cpu_read(16'hFFC1, 8'h00, "R3 hidden RAM init zero");
        cpu_write(16'hFFFE, 8'h3C);
        cpu_read(16'hFFFE, 8'h3C, "R4 write while hidden");
        cpu_write(16'h00F1, 8'h00);
        cpu_read(16'hFFC0, 8'hCD, "R3 ROM back");
        cpu_read(16'hFFFE, 8'hC0, "R3 ROM vector back");

        // R8 timer bits and readback
        cpu_write(16'h00F1, 8'h05);
        @(negedge clk);
        chk(16'(timer_en), 16'h5, "R8 timer_en");
        cpu_read(16'h00F1, 8'h05, "R8 control readback");
        drain();
        chk(16'(mem[16'h00F1]), 16'h00, "R9 control write kept out of RAM");

        // R9 plain RAM traffic
        cpu_write(16'h1234, 8'h5A);
        cpu_write(16'h00F0, 8'h33);
        cpu_read(16'h1234, 8'h5A, "R9 RAM readback");
        cpu_read(16'h00F0, 8'h33, "R9 RAM next to registers");

        // R5 host writes
        host_write(2'd2, 8'hBB);
        cpu_read(16'h00F6, 8'hBB, "R5 port 2");
        cpu_read(16'h00F4, 8'h00, "R5 port 0 untouched");
        host_write(2'd1, 8'h77);
        host_write(2'd0, 8'h11);
        cpu_read(16'h00F5, 8'h77, "R5 port 1");
        cpu_read(16'h00F4, 8'h11, "R5 port 0");
        cpu_read(16'h00F6, 8'hBB, "R5 port 2 kept");

        // R6 outbound latches
        cpu_write(16'h00F5, 8'hDD);
        cpu_write(16'h00F7, 8'hEE);
        @(negedge clk);
        host_ridx = 2'd1; #1;
        chk(16'(host_rdata), 16'hDD, "R6 outbound port 1");
        host_ridx = 2'd3; #1;
        chk(16'(host_rdata), 16'hEE, "R6 outbound port 3");
        cpu_read(16'h00F5, 8'h77, "R6 inbound port 1 unchanged");
        cpu_read(16'h00F7, 8'h00, "R6 inbound port 3 unchanged");
        drain();
        chk(16'(mem[16'h00F5]), 16'h00, "R9 port write kept out of RAM");

        // R7 back-to-back reads from four sources
        cpu_read(16'hFFC0, 8'hCD, "R7 ROM");
        cpu_read(16'h1234, 8'h5A, "R7 RAM");
        cpu_read(16'h00F4, 8'h11, "R7 mailbox");
        cpu_read(16'h00F1, 8'h05, "R7 control");
        cpu_read(16'h00F0, 8'h33, "R7 RAM again");

        // R10 host update racing coprocessor reads of the same port
        race_new_seen = 0;
        fork
            host_write(2'd0, 8'h99);
            begin
                for (int n = 0; n < 8; n++) cpu_read(16'h00F4, 8'h11, "R10 race", 1'b1, 8'h99);
            end
        join
        drain();
        chk(16'(race_new_seen), 16'h1, "R10 new value appeared");
        cpu_read(16'h00F4, 8'h99, "R10 settled");
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule